// File: doc/BRIEF.md
# Single-Wire Pulse-Count Mode Decoder

This block sits behind one active-low control pin and turns the activity on that pin into a device enable and an operating mode. Driving the pin low turns the device on. This happens only after the low level has lasted through a deglitch interval. A startup window then opens. During that window the controller may send a short train of high pulses to choose a current-limit mode or to switch on a production-test flag. The block times every high pulse and every low gap against a legal width range. It counts the legal pulses and latches a mode once the line has rested low long enough. A fourth pulse latches a mode at once, without that rest.

Once a mode is latched, the choice is fixed. Later pulses have no effect until the device is switched off and on again. Holding the pin high for longer than the idle limit switches the device off at any time. All timing counts a one-microsecond tick, which a prescaler derives from the system clock frequency parameter. The pin goes through a synchronizer before any timing is applied.

Top module: `pulse_mode_decoder`

## Requirements
- R1: While synchronous reset is asserted and after it is released with the pin held high, dev_en is 0, mode_code is 00, test_en is 0 and mode_stb is 0.
- R2: The startup window begins only after the synchronized pin has been low for DGL_US (50 µs). A low spell shorter than that does not start the window.
- R3: If no pulse is in progress when the WAIT_US window ends, the block latches the 500 mA host limit (mode_code 00). It also raises dev_en.
- R4: Inside the window, a high pulse counts only if it lasts between PMIN_US (100 µs) and PMAX_US (700 µs). A pulse outside that range clears the count, and the mode stays 00.
- R5: The low gap between two counted pulses must also lie between 100 µs and 700 µs. If the gap is outside that range, the count is cleared and the pulse that follows begins a fresh count.
- R6: With one to three pulses counted, nothing is latched until the pin has stayed low for IDLE_US (1500 µs) after the last falling edge. At that point dev_en rises.
- R7: The count maps to outputs as follows. One pulse gives mode_code 01 (externally set limit). Two pulses give 10 (100 mA host limit). Three pulses give test_en = 1 with mode_code 00.
- R8: When the fourth legal pulse falls, the block latches mode_code 10 at once and raises dev_en, without waiting for the idle time.
- R9: After a mode is latched, further pulses change neither mode_code, test_en nor dev_en, and they produce no strobe.
- R10: A high level that lasts longer than 1500 µs in any state turns dev_en off. A later low level starts a new programming window.
- R11: mode_stb is high for exactly one cycle each time a mode is latched, in the same cycle in which dev_en rises.
- R12: While dev_en is 0, mode_code is 00 and test_en is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high; forces the disabled state |
| prog_pin | input | 1 | Asynchronous control pin; low enables, high pulses program |
| dev_en | output | 1 | Device enabled (mode latched and running) |
| mode_code | output | 2 | 00 = 500 mA host limit, 01 = external limit, 10 = 100 mA host limit |
| test_en | output | 1 | Production-test flag |
| mode_stb | output | 1 | One-cycle strobe when a mode is latched |

## Verification
The bench sends a low glitch shorter than the deglitch time ahead of a real enable. It then samples dev_en on both sides of the expected start-up instant, so a design without the deglitch starts about 50 µs too early and is caught. Pulses that are too short or too long, and gaps that are too short or too long, are each sent between legal pulses. A design that does not check one of these windows ends in mode 10 or 01 where 00 or 01 is expected. The fourth pulse is checked 60 µs after its falling edge, which catches a design that waits for the idle timeout. Extra pulses after the latch expose a design that does not lock its mode. A high level of 1400 µs followed by 1700 µs checks that the device turns off only after the idle limit.

// File: rtl/pmd_pkg.sv
package pmd_pkg;

   // current-limit selection carried on mode_code
   typedef enum logic [1:0] {
      LIM_500 = 2'b00,
      LIM_EXT = 2'b01,
      LIM_100 = 2'b10
   } lim_e;

   typedef enum logic [1:0] {
      ST_OFF = 2'b00,
      ST_WIN = 2'b01,
      ST_RUN = 2'b10
   } st_e;

   // map a settled pulse count to a limit; three pulses keep the default limit
   function automatic lim_e lim_of(input int n);
      case (n)
         1:       lim_of = LIM_EXT;
         2:       lim_of = LIM_100;
         3:       lim_of = LIM_500;
         default: lim_of = LIM_100;
      endcase
   endfunction

endpackage

// File: rtl/pmd_tick.sv
// Divides the system clock into a one-cycle pulse every microsecond.
module pmd_tick #(
   parameter int DIV = 250
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad
         $error("pmd_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         logic tick_q;
         always_ff @(posedge clk) tick_q <= ~rst;
         assign tick = tick_q;
      end else begin : g_div
         localparam int W = $clog2(DIV);
         logic [W-1:0] cnt_q;
         logic         tick_q;
         always_ff @(posedge clk) begin
            if (rst) begin
               cnt_q  <= '0;
               tick_q <= 1'b0;
            end else if (cnt_q == W'(DIV - 1)) begin
               cnt_q  <= '0;
               tick_q <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + 1'b1;
               tick_q <= 1'b0;
            end
         end
         assign tick = tick_q;
      end
   endgenerate
endmodule

// File: rtl/pmd_sync.sv
// Multi-stage synchronizer for the asynchronous pin.
module pmd_sync #(
   parameter int   STAGES  = 2,
   parameter logic IDLE_LV = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pmd_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (rst) chain_q <= {STAGES{IDLE_LV}};
      else     chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pmd_satcnt.sv
// Saturating up-counter of microsecond ticks with a synchronous clear.
module pmd_satcnt #(
   parameter int MAX = 1501,
   localparam int W  = $clog2(MAX + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] val
);
   always_ff @(posedge clk) begin
      if (rst || clr)                 val <= '0;
      else if (inc && val != W'(MAX)) val <= val + 1'b1;
   end
endmodule

// File: rtl/pulse_mode_decoder.sv
module pulse_mode_decoder #(
   parameter int CLK_HZ      = 250_000_000,
   parameter int SYNC_STAGES = 2,
   parameter int DGL_US      = 50,
   parameter int WAIT_US     = 32000,
   parameter int PMIN_US     = 100,
   parameter int PMAX_US     = 700,
   parameter int IDLE_US     = 1500,
   parameter int EARLY_CNT   = 4
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       prog_pin,
   output logic       dev_en,
   output logic [1:0] mode_code,
   output logic       test_en,
   output logic       mode_stb
);
   import pmd_pkg::*;

   localparam int CLK_PER_US = CLK_HZ / 1_000_000;
   localparam int PH_MAX     = IDLE_US + 1;
   localparam int PH_W       = $clog2(PH_MAX + 1);
   localparam int WIN_W      = $clog2(WAIT_US + 1);
   localparam int CW         = $clog2(EARLY_CNT + 1);

   generate
      if (CLK_PER_US < 1) begin : g_bad_clk
         $error("pulse_mode_decoder: CLK_HZ below 1 MHz");
      end
      if (PMIN_US >= PMAX_US || PMAX_US >= IDLE_US || DGL_US >= IDLE_US) begin : g_bad_win
         $error("pulse_mode_decoder: inconsistent width windows");
      end
      if (EARLY_CNT < 4 || EARLY_CNT > 7) begin : g_bad_cnt
         $error("pulse_mode_decoder: EARLY_CNT out of range");
      end
   endgenerate

   logic             us_tick;
   logic             pin_s, pin_d;
   logic             edge_seen, rise, fall;
   logic [PH_W-1:0]  ph_us;
   logic [WIN_W-1:0] win_us;

   pmd_tick #(.DIV(CLK_PER_US)) u_tick (
      .clk(clk), .rst(rst), .tick(us_tick)
   );

   pmd_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync (
      .clk(clk), .rst(rst), .d(prog_pin), .q(pin_s)
   );

   always_ff @(posedge clk) begin
      if (rst) pin_d <= 1'b1;
      else     pin_d <= pin_s;
   end

   assign edge_seen = pin_s ^ pin_d;
   assign rise      = pin_s & ~pin_d;
   assign fall      = ~pin_s & pin_d;

   st_e             st_q, st_n;
   logic [CW-1:0]   cnt_q, cnt_n;
   lim_e            lim_q, lim_n;
   logic            tst_q, tst_n;
   logic            stb_q, stb_n;

   // duration of the current level; at an edge it still holds the finished phase
   pmd_satcnt #(.MAX(PH_MAX)) u_phase (
      .clk(clk), .rst(rst), .clr(edge_seen), .inc(us_tick), .val(ph_us)
   );

   // elapsed programming window
   pmd_satcnt #(.MAX(WAIT_US)) u_window (
      .clk(clk), .rst(rst), .clr(st_q != ST_WIN), .inc(us_tick), .val(win_us)
   );

   logic low_dgl, low_idle, hi_long, hi_ok, gap_ok, win_done;

   assign low_dgl  = ~pin_d && (ph_us >= PH_W'(DGL_US));
   assign low_idle = ~pin_d && (ph_us >= PH_W'(IDLE_US));
   assign hi_long  =  pin_d && (ph_us >  PH_W'(IDLE_US));
   assign hi_ok    = (ph_us >= PH_W'(PMIN_US)) && (ph_us <= PH_W'(PMAX_US));
   assign gap_ok   = hi_ok;
   assign win_done = (win_us >= WIN_W'(WAIT_US));

   always_comb begin
      st_n  = st_q;
      cnt_n = cnt_q;
      lim_n = lim_q;
      tst_n = tst_q;
      stb_n = 1'b0;
      unique case (st_q)
         ST_OFF: begin
            if (low_dgl) begin
               st_n  = ST_WIN;
               cnt_n = '0;
            end
         end
         ST_WIN: begin
            if (hi_long) begin
               st_n  = ST_OFF;
               cnt_n = '0;
            end else if (fall) begin
               if (!hi_ok) begin
                  cnt_n = '0;
               end else if (cnt_q == CW'(EARLY_CNT - 1)) begin
                  cnt_n = cnt_q + 1'b1;
                  st_n  = ST_RUN;
                  lim_n = LIM_100;
                  stb_n = 1'b1;
               end else begin
                  cnt_n = cnt_q + 1'b1;
               end
            end else if (rise) begin
               if (cnt_q != '0 && !gap_ok) cnt_n = '0;
            end else if (cnt_q != '0 && low_idle) begin
               st_n  = ST_RUN;
               lim_n = lim_of(int'(cnt_q));
               tst_n = (cnt_q == CW'(3));
               stb_n = 1'b1;
            end else if (cnt_q == '0 && ~pin_d && win_done) begin
               st_n  = ST_RUN;
               lim_n = LIM_500;
               stb_n = 1'b1;
            end
         end
         ST_RUN: begin
            if (hi_long) begin
               st_n  = ST_OFF;
               lim_n = LIM_500;
               tst_n = 1'b0;
               cnt_n = '0;
            end
         end
         default: st_n = ST_OFF;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_OFF;
         cnt_q <= '0;
         lim_q <= LIM_500;
         tst_q <= 1'b0;
         stb_q <= 1'b0;
      end else begin
         st_q  <= st_n;
         cnt_q <= cnt_n;
         lim_q <= lim_n;
         tst_q <= tst_n;
         stb_q <= stb_n;
      end
   end

   assign dev_en    = (st_q == ST_RUN);
   assign mode_code = lim_q;
   assign test_en   = tst_q;
   assign mode_stb  = stb_q;

endmodule

// File: rtl/pulse_mode_decoder_chk.sv
module pulse_mode_decoder_chk (
   input logic       clk,
   input logic       rst,
   input logic       prog_pin,
   input logic       dev_en,
   input logic [1:0] mode_code,
   input logic       test_en,
   input logic       mode_stb
);
   // R11: strobe lasts a single cycle
   p_stb_single_r11: assert property (@(posedge clk) disable iff (rst)
      mode_stb |=> !mode_stb);

   // R11: enable rises together with the latch strobe
   p_en_with_stb_r11: assert property (@(posedge clk) disable iff (rst)
      $rose(dev_en) |-> mode_stb);

   // R9: outputs frozen while running
   p_locked_r9: assert property (@(posedge clk) disable iff (rst)
      (dev_en && $past(dev_en)) |-> ($stable(mode_code) && $stable(test_en) && !mode_stb));

   // R12: defaults while not enabled
   p_off_defaults_r12: assert property (@(posedge clk) disable iff (rst)
      !dev_en |-> (mode_code == 2'b00 && !test_en));

   // R7: test flag only with the default limit, and no reserved code
   p_test_code_r7: assert property (@(posedge clk) disable iff (rst)
      (test_en |-> mode_code == 2'b00) and (mode_code != 2'b11));

   // R10: switching off only follows a high pin
   p_off_from_high_r10: assert property (@(posedge clk) disable iff (rst)
      $fell(dev_en) |-> $past(prog_pin));
endmodule

bind pulse_mode_decoder pulse_mode_decoder_chk u_chk (
   .clk(clk), .rst(rst), .prog_pin(prog_pin), .dev_en(dev_en),
   .mode_code(mode_code), .test_en(test_en), .mode_stb(mode_stb)
);

// File: tb/tb_pulse_mode_decoder.sv
module tb_pulse_mode_decoder;
   // timing is scaled: the clock is declared to the DUT as 2 MHz, so 2 cycles per microsecond
   localparam int CPU = 2;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       prog_pin = 1'b1;
   logic       dev_en;
   logic [1:0] mode_code;
   logic       test_en;
   logic       mode_stb;

   int n_chk = 0;
   int n_bad = 0;
   int stb_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pulse_mode_decoder #(
      .CLK_HZ(2_000_000),
      .WAIT_US(1000)
   ) dut (
      .clk(clk), .rst(rst), .prog_pin(prog_pin), .dev_en(dev_en),
      .mode_code(mode_code), .test_en(test_en), .mode_stb(mode_stb)
   );

   always @(posedge clk) if (!rst && mode_stb) stb_cnt++;

   task automatic run_us(input int n);
      repeat (n * CPU) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic pulse(input int hi_us);
      prog_pin = 1'b1;
      run_us(hi_us);
      prog_pin = 1'b0;
   endtask

   task automatic go_off();
      prog_pin = 1'b1;
      run_us(1700);
      check("R10", "off after long high", int'(dev_en), 0);
   endtask

   task automatic t_reset();
      check("R1", "dev_en", int'(dev_en), 0);
      check("R1", "mode_code", int'(mode_code), 0);
      check("R1", "test_en", int'(test_en), 0);
      check("R1", "mode_stb", int'(mode_stb), 0);
   endtask

   task automatic t_startup();
      int s;
      prog_pin = 1'b0;
      run_us(30);
      prog_pin = 1'b1;
      run_us(200);
      s = stb_cnt;
      prog_pin = 1'b0;
      run_us(500);
      check("R12", "window mode", int'(mode_code), 0);
      run_us(530);
      check("R2", "not yet enabled", int'(dev_en), 0);
      run_us(40);
      check("R3", "enabled after window", int'(dev_en), 1);
      check("R3", "default mode", int'(mode_code), 0);
      check("R11", "one strobe", stb_cnt - s, 1);
   endtask

   task automatic t_map(input int n, input int exp_mode, input int exp_test, input string tag);
      int s;
      go_off();
      s = stb_cnt;
      prog_pin = 1'b0;
      run_us(100);
      for (int i = 0; i < n; i++) begin
         pulse(300);
         if (i != n - 1) run_us(300);
      end
      run_us(1400);
      check("R6", "held before idle", int'(dev_en), 0);
      check("R12", "mode before idle", int'(mode_code), 0);
      run_us(200);
      check("R6", "enabled after idle", int'(dev_en), 1);
      check("R7", {tag, " mode"}, int'(mode_code), exp_mode);
      check("R7", {tag, " test"}, int'(test_en), exp_test);
      check("R11", {tag, " strobe"}, stb_cnt - s, 1);
   endtask

   task automatic t_early();
      int s;
      go_off();
      s = stb_cnt;
      prog_pin = 1'b0;
      run_us(100);
      for (int i = 0; i < 4; i++) begin
         pulse(300);
         if (i != 3) run_us(300);
      end
      run_us(60);
      check("R8", "early enable", int'(dev_en), 1);
      check("R8", "early mode", int'(mode_code), 2);
      run_us(300);
      pulse(300);
      run_us(300);
      pulse(300);
      run_us(1600);
      check("R9", "mode kept", int'(mode_code), 2);
      check("R9", "test kept", int'(test_en), 0);
      check("R9", "still enabled", int'(dev_en), 1);
      check("R9", "no extra strobe", stb_cnt - s, 1);
      prog_pin = 1'b1;
      run_us(1400);
      check("R10", "on below limit", int'(dev_en), 1);
      run_us(300);
      check("R10", "off past limit", int'(dev_en), 0);
      check("R12", "off mode", int'(mode_code), 0);
      check("R12", "off test", int'(test_en), 0);
   endtask

   task automatic t_bad_pulse(input int hi_us, input string tag);
      go_off();
      prog_pin = 1'b0;
      run_us(100);
      if (hi_us < 100) begin
         pulse(300);
         run_us(300);
      end
      pulse(hi_us);
      run_us(1700);
      check("R4", {tag, " enabled"}, int'(dev_en), 1);
      check("R4", {tag, " mode"}, int'(mode_code), 0);
      check("R4", {tag, " test"}, int'(test_en), 0);
   endtask

   task automatic t_bad_gap(input int gap_us, input string tag);
      go_off();
      prog_pin = 1'b0;
      run_us(100);
      pulse(300);
      run_us(gap_us);
      pulse(300);
      run_us(1700);
      check("R5", {tag, " enabled"}, int'(dev_en), 1);
      check("R5", {tag, " mode"}, int'(mode_code), 1);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #1;
      t_reset();
      rst = 1'b0;
      run_us(10);
      t_reset();
      t_startup();
      t_map(1, 1, 0, "one");
      t_map(2, 2, 0, "two");
      t_map(3, 0, 1, "three");
      t_early();
      t_bad_pulse(40, "short");
      t_bad_pulse(900, "long");
      t_bad_gap(1000, "long gap");
      t_bad_gap(40, "short gap");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule